// File: doc/BRIEF.md
# PCM codec serial transceiver

This block is a full-duplex serial port for an external audio codec. It divides the incoming codec clock into a free-running serial bit clock. It emits a frame sync pulse one bit clock wide, once every programmable number of bit clocks. In every frame it shifts one 16-bit word out, most significant bit first, and the word comes from a first-word-fall-through transmit FIFO port. At the same time it collects one 16-bit word from the serial input and writes it to a receive FIFO port.

For each direction, the first bit can coincide with the sync bit period or start one bit clock later. The block can pulse an interrupt when the last transmit bit has gone out. It derives two watermark interrupts from the occupancy counts that the FIFOs report. Sticky flags record a transmit underrun and a receive overrun. A global enable stops the port. While it is low, every output is held low and all counters and flags are cleared.

Top module: `pcm_xcvr`

## Requirements
- R1: The bit clock `sclk` has a period of `div_val` codec clocks (`div_val` >= 2) and stays high for `div_val/2` (rounded down) codec clocks of each period.
- R2: `sync` is high for exactly one bit period, and it repeats every `frame_len` bit clocks (`frame_len` >= 17). The first sync covers the first bit period after `enable` rises. `sync` changes only on a rising edge of `sclk`.
- R3: `sdout` changes only on rising edges of `sclk`. Bit 15 of the frame word is sent in the sync period when `tx_msb_late`=0, or in the following period when it is 1. Bits 14 down to 0 follow in consecutive periods. In every other period of the frame `sdout` is 0.
- R4: `sdin` is sampled on falling edges of `sclk`. The first sample taken in the sync period (`rx_msb_late`=0) or in the period after it (`rx_msb_late`=1) becomes bit 15. After the sixteenth sample the word is written with a one-cycle `rx_push` pulse on `rx_data`. Later bits in the frame are ignored.
- R5: At the rising edge that starts a frame, `tx_pop` pulses for one cycle if `tx_empty` is 0, and `tx_data` becomes the frame word. If `tx_empty` is 1, there is no pop, the frame word is all zeros and `underrun` is set and stays set.
- R6: If `rx_full` is high when a received word completes, the word is discarded with no `rx_push`, and `overrun` is set and stays set.
- R7: When `tx_done_en` is 1, `tx_done_irq` pulses for one cycle at the rising edge that ends the sixteenth transmit bit period. When `tx_done_en` is 0, it never pulses.
- R8: `rx_afull_irq` is 1 exactly when `rx_fifo_level` > `rx_afull_lvl`, one cycle after the inputs.
- R9: `tx_aempty_irq` is 1 exactly when `tx_fifo_level` <= `tx_aempty_lvl`, one cycle after the inputs.
- R10: While `enable` is 0 (and during reset), `sclk`, `sync`, `sdout`, `tx_pop`, `rx_push`, all interrupts, `underrun` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low holds and clears everything |
| div_val | input | DIV_W | Codec clocks per bit clock |
| frame_len | input | FRAME_W | Bit clocks per frame |
| tx_msb_late | input | 1 | Transmit MSB one bit clock after sync |
| rx_msb_late | input | 1 | Receive MSB one bit clock after sync |
| tx_done_en | input | 1 | Enables the transmit-word-done pulse |
| rx_afull_lvl | input | LVL_W | Receive almost-full threshold |
| tx_aempty_lvl | input | LVL_W | Transmit almost-empty threshold |
| rx_fifo_level | input | LVL_W | Receive FIFO occupancy |
| tx_fifo_level | input | LVL_W | Transmit FIFO occupancy |
| tx_data | input | 16 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO read strobe |
| rx_data | output | 16 | Received word |
| rx_push | output | 1 | Receive FIFO write strobe |
| rx_full | input | 1 | Receive FIFO full |
| sdin | input | 1 | Serial data from codec |
| sclk | output | 1 | Serial bit clock |
| sync | output | 1 | Frame sync |
| sdout | output | 1 | Serial data to codec |
| tx_done_irq | output | 1 | Transmit word done pulse |
| rx_afull_irq | output | 1 | Receive almost-full interrupt |
| tx_aempty_irq | output | 1 | Transmit almost-empty interrupt |
| underrun | output | 1 | Sticky transmit underrun |
| overrun | output | 1 | Sticky receive overrun |

## Verification
A phase or bit counter that is off by one shows up within one bit period. It appears as a wrong `sclk` high time or period, or as `sync` landing on the wrong bit clock. A slip in the word index shifts `sdout` by a position, or puts data in the guard periods. The bench sees that error in the first frame, and it also sees a received word that is rotated by one bit when it is pushed. A flag or interrupt that was never armed, or never cleared, appears at the end of the frame or two cycles after a threshold input changes.

// File: rtl/pcm_pkg.sv
`timescale 1ns/1ps
package pcm_pkg;
   localparam int WORD_W = 16;
   localparam int WIDX_W = $clog2(WORD_W);
endpackage

// File: rtl/pcm_clkgen.sv
`timescale 1ns/1ps
// Bit-clock divider, frame position counter and sync generator.
module pcm_clkgen #(
   parameter int DIV_W   = 8,
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [DIV_W-1:0]   div_val,
   input  logic [FRAME_W-1:0] frame_len,
   output logic               sclk,
   output logic               sync,
   output logic               rise,
   output logic               fall,
   output logic               run,
   output logic [FRAME_W-1:0] bc,
   output logic [FRAME_W-1:0] nbc
);
   logic [DIV_W-1:0] ph;
   logic [DIV_W-1:0] half;

   assign half = div_val >> 1;
   assign rise = en && (ph == div_val - DIV_W'(1));
   assign fall = en && run && (ph == half - DIV_W'(1));
   assign nbc  = (!run || bc == frame_len - FRAME_W'(1)) ? '0 : bc + FRAME_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= '0;
         sclk <= 1'b0;
         sync <= 1'b0;
         run  <= 1'b0;
         bc   <= '0;
      end else if (!en) begin
         ph   <= '0;
         sclk <= 1'b0;
         sync <= 1'b0;
         run  <= 1'b0;
         bc   <= '0;
      end else begin
         ph <= rise ? '0 : ph + DIV_W'(1);
         if (rise) begin
            sclk <= 1'b1;
            run  <= 1'b1;
            bc   <= nbc;
            sync <= (nbc == '0);
         end else if (fall) begin
            sclk <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pcm_tx.sv
`timescale 1ns/1ps
// Transmit serializer: loads one word per frame, shifts on rising edges.
module pcm_tx
   import pcm_pkg::*;
#(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               rise,
   input  logic               run,
   input  logic [FRAME_W-1:0] bc,
   input  logic [FRAME_W-1:0] nbc,
   input  logic               late,
   input  logic               done_en,
   input  logic [WORD_W-1:0]  tx_data,
   input  logic               tx_empty,
   output logic               tx_pop,
   output logic               sdout,
   output logic               done_irq,
   output logic               underrun
);
   logic [WORD_W-1:0]  word_q;
   logic [WORD_W-1:0]  src;
   logic [FRAME_W-1:0] lat;
   logic [FRAME_W-1:0] tidx;
   logic [FRAME_W-1:0] didx;
   logic [WIDX_W-1:0]  bsel;
   logic               start;
   logic               in_w;
   logic               last;

   assign lat    = {{(FRAME_W-1){1'b0}}, late};
   assign start  = rise && (nbc == '0);
   assign tx_pop = start && !tx_empty;
   assign src    = start ? (tx_empty ? '0 : tx_data) : word_q;
   assign tidx   = nbc - lat;
   assign in_w   = (nbc >= lat) && (tidx < FRAME_W'(WORD_W));
   assign bsel   = WIDX_W'(WORD_W-1) - tidx[WIDX_W-1:0];
   assign didx   = bc - lat;
   assign last   = run && (bc >= lat) && (didx == FRAME_W'(WORD_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         sdout    <= 1'b0;
         done_irq <= 1'b0;
         underrun <= 1'b0;
      end else if (!en) begin
         word_q   <= '0;
         sdout    <= 1'b0;
         done_irq <= 1'b0;
         underrun <= 1'b0;
      end else begin
         done_irq <= 1'b0;
         if (start) begin
            word_q <= src;
            if (tx_empty) underrun <= 1'b1;
         end
         if (rise) begin
            sdout    <= in_w ? src[bsel] : 1'b0;
            done_irq <= last && done_en;
         end
      end
   end
endmodule

// File: rtl/pcm_rx.sv
`timescale 1ns/1ps
// Receive deserializer: samples on falling edges, pushes the first word.
module pcm_rx
   import pcm_pkg::*;
#(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               fall,
   input  logic [FRAME_W-1:0] bc,
   input  logic               late,
   input  logic               sdin,
   input  logic               rx_full,
   output logic [WORD_W-1:0]  rx_data,
   output logic               rx_push,
   output logic               overrun
);
   logic [WORD_W-1:0]  sh;
   logic [FRAME_W-1:0] lat;
   logic [FRAME_W-1:0] ridx;
   logic               in_w;

   assign lat  = {{(FRAME_W-1){1'b0}}, late};
   assign ridx = bc - lat;
   assign in_w = (bc >= lat) && (ridx < FRAME_W'(WORD_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         rx_data <= '0;
         rx_push <= 1'b0;
         overrun <= 1'b0;
      end else if (!en) begin
         sh      <= '0;
         rx_data <= '0;
         rx_push <= 1'b0;
         overrun <= 1'b0;
      end else begin
         rx_push <= 1'b0;
         if (fall && in_w) begin
            sh <= {sh[WORD_W-2:0], sdin};
            if (ridx == FRAME_W'(WORD_W-1)) begin
               if (rx_full) begin
                  overrun <= 1'b1;
               end else begin
                  rx_data <= {sh[WORD_W-2:0], sdin};
                  rx_push <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pcm_wmark.sv
`timescale 1ns/1ps
// Registered FIFO watermark compare; ABOVE picks strict-greater or at-or-below.
module pcm_wmark #(
   parameter int LVL_W = 5,
   parameter bit ABOVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] thresh,
   output logic             irq
);
   logic hit;

   generate
      if (ABOVE) begin : g_above
         assign hit = level > thresh;
      end else begin : g_below
         assign hit = level <= thresh;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= en && hit;
   end
endmodule

// File: rtl/pcm_xcvr.sv
`timescale 1ns/1ps
module pcm_xcvr
   import pcm_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int FRAME_W = 8,
   parameter int LVL_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [DIV_W-1:0]   div_val,
   input  logic [FRAME_W-1:0] frame_len,
   input  logic               tx_msb_late,
   input  logic               rx_msb_late,
   input  logic               tx_done_en,
   input  logic [LVL_W-1:0]   rx_afull_lvl,
   input  logic [LVL_W-1:0]   tx_aempty_lvl,
   input  logic [LVL_W-1:0]   rx_fifo_level,
   input  logic [LVL_W-1:0]   tx_fifo_level,
   input  logic [15:0]        tx_data,
   input  logic               tx_empty,
   output logic               tx_pop,
   output logic [15:0]        rx_data,
   output logic               rx_push,
   input  logic               rx_full,
   input  logic               sdin,
   output logic               sclk,
   output logic               sync,
   output logic               sdout,
   output logic               tx_done_irq,
   output logic               rx_afull_irq,
   output logic               tx_aempty_irq,
   output logic               underrun,
   output logic               overrun
);
   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must allow a divider of at least 2");
      end
      if (FRAME_W < 5) begin : g_bad_frame
         $error("FRAME_W must hold a frame of at least 17 bit clocks");
      end
      if (WORD_W != 16) begin : g_bad_word
         $error("word width is fixed at 16");
      end
   endgenerate

   logic               rise, fall, run;
   logic [FRAME_W-1:0] bc, nbc;

   pcm_clkgen #(.DIV_W(DIV_W), .FRAME_W(FRAME_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .en(enable), .div_val(div_val),
      .frame_len(frame_len), .sclk(sclk), .sync(sync), .rise(rise),
      .fall(fall), .run(run), .bc(bc), .nbc(nbc)
   );

   pcm_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(enable), .rise(rise), .run(run),
      .bc(bc), .nbc(nbc), .late(tx_msb_late), .done_en(tx_done_en),
      .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
      .sdout(sdout), .done_irq(tx_done_irq), .underrun(underrun)
   );

   pcm_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(enable), .fall(fall), .bc(bc),
      .late(rx_msb_late), .sdin(sdin), .rx_full(rx_full),
      .rx_data(rx_data), .rx_push(rx_push), .overrun(overrun)
   );

   pcm_wmark #(.LVL_W(LVL_W), .ABOVE(1'b1)) u_rx_wm (
      .clk(clk), .rst_n(rst_n), .en(enable), .level(rx_fifo_level),
      .thresh(rx_afull_lvl), .irq(rx_afull_irq)
   );

   pcm_wmark #(.LVL_W(LVL_W), .ABOVE(1'b0)) u_tx_wm (
      .clk(clk), .rst_n(rst_n), .en(enable), .level(tx_fifo_level),
      .thresh(tx_aempty_lvl), .irq(tx_aempty_irq)
   );
endmodule

// File: rtl/pcm_xcvr_chk.sv
`timescale 1ns/1ps
module pcm_xcvr_chk #(
   parameter int LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             sclk,
   input logic             sync,
   input logic             sdout,
   input logic             tx_pop,
   input logic             rx_push,
   input logic             rx_full,
   input logic             underrun,
   input logic             tx_done_irq,
   input logic             tx_done_en,
   input logic             rx_afull_irq,
   input logic             tx_aempty_irq,
   input logic [LVL_W-1:0] rx_fifo_level,
   input logic [LVL_W-1:0] rx_afull_lvl,
   input logic [LVL_W-1:0] tx_fifo_level,
   input logic [LVL_W-1:0] tx_aempty_lvl
);
   // R2
   sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      !$stable(sync) |-> $rose(sclk));
   // R3
   sdout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      !$stable(sdout) |-> $rose(sclk));
   // R4
   push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      rx_push |=> !rx_push);
   // R5
   pop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      tx_pop |=> (sync && $rose(sclk)));
   // R5
   underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      underrun |=> underrun);
   // R6
   push_full_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      rx_push |-> !$past(rx_full));
   // R7
   done_en_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      tx_done_irq |-> $past(tx_done_en));
   // R8
   afull_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      rx_afull_irq |-> ($past(rx_fifo_level) > $past(rx_afull_lvl)));
   // R9
   aempty_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
      tx_aempty_irq |-> ($past(tx_fifo_level) <= $past(tx_aempty_lvl)));
endmodule

bind pcm_xcvr pcm_xcvr_chk #(.LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .sclk(sclk), .sync(sync),
   .sdout(sdout), .tx_pop(tx_pop), .rx_push(rx_push), .rx_full(rx_full),
   .underrun(underrun), .tx_done_irq(tx_done_irq), .tx_done_en(tx_done_en),
   .rx_afull_irq(rx_afull_irq), .tx_aempty_irq(tx_aempty_irq),
   .rx_fifo_level(rx_fifo_level), .rx_afull_lvl(rx_afull_lvl),
   .tx_fifo_level(tx_fifo_level), .tx_aempty_lvl(tx_aempty_lvl)
);

// File: tb/pcm_xcvr_tb.sv
`timescale 1ns/1ps
module pcm_xcvr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [7:0]  div_val = 8'd4;
   logic [7:0]  frame_len = 8'd17;
   logic        tx_msb_late = 1'b0, rx_msb_late = 1'b0, tx_done_en = 1'b0;
   logic [4:0]  rx_afull_lvl = '0, tx_aempty_lvl = '0;
   logic [4:0]  rx_fifo_level = '0, tx_fifo_level = '0;
   logic [15:0] tx_data = '0;
   logic        tx_empty = 1'b0, rx_full = 1'b0, sdin = 1'b1;
   logic        tx_pop, rx_push, sclk, sync, sdout;
   logic        tx_done_irq, rx_afull_irq, tx_aempty_irq, underrun, overrun;
   logic [15:0] rx_data;

   int total = 0, bad = 0, cyc = 0;
   int n_pop = 0, n_push = 0, n_done = 0;
   logic [15:0] last_rx = '0;

   always #10 clk = ~clk;

   pcm_xcvr u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
      .frame_len(frame_len), .tx_msb_late(tx_msb_late), .rx_msb_late(rx_msb_late),
      .tx_done_en(tx_done_en), .rx_afull_lvl(rx_afull_lvl), .tx_aempty_lvl(tx_aempty_lvl),
      .rx_fifo_level(rx_fifo_level), .tx_fifo_level(tx_fifo_level),
      .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_data(rx_data),
      .rx_push(rx_push), .rx_full(rx_full), .sdin(sdin), .sclk(sclk), .sync(sync),
      .sdout(sdout), .tx_done_irq(tx_done_irq), .rx_afull_irq(rx_afull_irq),
      .tx_aempty_irq(tx_aempty_irq), .underrun(underrun), .overrun(overrun)
   );

   always @(negedge clk) begin
      cyc++;
      if (tx_pop) n_pop++;
      if (rx_push) begin n_push++; last_rx = rx_data; end
      if (tx_done_irq) n_done++;
      if (cyc == 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // txw, rxw, tx late, rx late, frame length, divider, done enable
   localparam logic [50:0] VECS [5] = '{
      {16'hA5C3, 16'h3C5A, 1'b0, 1'b0, 8'd17, 8'd4, 1'b1},
      {16'h8001, 16'hFFFE, 1'b1, 1'b0, 8'd17, 8'd2, 1'b1},
      {16'h1234, 16'h8421, 1'b0, 1'b1, 8'd20, 8'd3, 1'b0},
      {16'hFFFF, 16'h0001, 1'b1, 1'b1, 8'd24, 8'd5, 1'b1},
      {16'h0F0F, 16'hF00D, 1'b0, 1'b0, 8'd32, 8'd6, 1'b0}
   };

   task automatic run_frame(input logic [15:0] txw, input logic [15:0] rxw,
                            input logic tl, input logic rl, input int flen, input int dv,
                            input logic ie, input logic emp, input logic full);
      int k, n, hi, t, e_sd, e_sy, e_dv, e_hi, p0, q0, d0;
      logic prev;
      enable = 1'b0;
      repeat (3) @(negedge clk);
      div_val = 8'(dv); frame_len = 8'(flen);
      tx_msb_late = tl; rx_msb_late = rl; tx_done_en = ie;
      tx_data = txw; tx_empty = emp; rx_full = full; sdin = 1'b1;
      p0 = n_pop; q0 = n_push; d0 = n_done;
      @(negedge clk);
      enable = 1'b1;
      k = 0; n = 0; hi = 0; t = 0; e_sd = 0; e_sy = 0; e_dv = 0; e_hi = 0; prev = 1'b0;
      while (k <= flen && t < 5000) begin
         @(negedge clk);
         t++;
         if (sclk && !prev) begin
            int kk, ti, ri;
            logic exp_sd;
            if (k > 0 && n != dv) e_dv++;
            if (k > 0 && hi != dv / 2) e_hi++;
            n = 0; hi = 0;
            kk = (k == flen) ? 0 : k;
            ti = kk - int'(tl);
            exp_sd = (ti >= 0 && ti < 16 && !emp) ? txw[15 - ti] : 1'b0;
            if (sync !== (kk == 0)) e_sy++;
            if (sdout !== exp_sd) e_sd++;
            ri = kk - int'(rl);
            sdin = (ri >= 0 && ri < 16) ? rxw[15 - ri] : ~rxw[0];
            k++;
         end
         n++;
         if (sclk) hi++;
         prev = sclk;
      end
      repeat (2) @(negedge clk);
      // R1
      check(e_dv == 0 && t < 5000, "R1 period", e_dv, 0);
      check(e_hi == 0, "R1 high time", e_hi, 0);
      // R2
      check(e_sy == 0, "R2 sync placement", e_sy, 0);
      // R3
      check(e_sd == 0, "R3 serial out bits", e_sd, 0);
      // R4 / R6
      check((n_push - q0) == (full ? 0 : 1), "R4 R6 push count", n_push - q0, full ? 0 : 1);
      if (!full) check(last_rx === rxw, "R4 received word", last_rx, rxw);
      // R5
      check((n_pop - p0) == (emp ? 0 : 2), "R5 pop count", n_pop - p0, emp ? 0 : 2);
      check(underrun === emp, "R5 underrun flag", underrun, emp);
      // R6
      check(overrun === full, "R6 overrun flag", overrun, full);
      // R7
      check((n_done - d0) == (ie ? 1 : 0), "R7 done pulses", n_done - d0, ie ? 1 : 0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R10 reset state
      check({sclk, sync, sdout, tx_pop, rx_push, tx_done_irq, rx_afull_irq,
             tx_aempty_irq, underrun, overrun} === '0, "R10 reset outputs", sclk, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 5; i++) begin
         logic [50:0] v;
         v = VECS[i];
         run_frame(v[50:35], v[34:19], v[18], v[17], int'(v[16:9]), int'(v[8:1]),
                   v[0], 1'b0, 1'b0);
      end

      // R5 R6 underrun and overrun in one frame
      run_frame(16'hFFFF, 16'h1357, 1'b0, 1'b0, 18, 4, 1'b1, 1'b1, 1'b1);

      // R10 disable clears flags and holds outputs
      enable = 1'b0;
      repeat (2) @(negedge clk);
      check({underrun, overrun} === 2'b00, "R10 flags cleared", {underrun, overrun}, 0);
      begin
         int seen;
         seen = 0;
         tx_empty = 1'b0; rx_fifo_level = 5'd9; rx_afull_lvl = 5'd2;
         repeat (20) begin
            @(negedge clk);
            if (sclk | sync | sdout | tx_pop | rx_push | rx_afull_irq) seen++;
         end
         check(seen == 0, "R10 outputs held low", seen, 0);
      end

      // R8 R9 watermark boundaries
      enable = 1'b1;
      rx_afull_lvl = 5'd5; rx_fifo_level = 5'd5;
      tx_aempty_lvl = 5'd3; tx_fifo_level = 5'd3;
      repeat (2) @(negedge clk);
      check(rx_afull_irq === 1'b0, "R8 level equal", rx_afull_irq, 0);
      check(tx_aempty_irq === 1'b1, "R9 level equal", tx_aempty_irq, 1);
      rx_fifo_level = 5'd6; tx_fifo_level = 5'd4;
      repeat (2) @(negedge clk);
      check(rx_afull_irq === 1'b1, "R8 level above", rx_afull_irq, 1);
      check(tx_aempty_irq === 1'b0, "R9 level above", tx_aempty_irq, 0);
      rx_fifo_level = 5'd0; tx_fifo_level = 5'd0;
      repeat (2) @(negedge clk);
      check(rx_afull_irq === 1'b0, "R8 level zero", rx_afull_irq, 0);
      check(tx_aempty_irq === 1'b1, "R9 level zero", tx_aempty_irq, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule